// File: doc/BRIEF.md
# Priority Throttle Arbiter

This block merges seven independent clock-throttle requests into one throttle setting. Two of the requests come from temperature thresholds: a mild one and a severe one. The other five come from overcurrent alarms. Each request has three programmed values: a priority, a CPU clock pulse-skip depth in percent, and a two-bit GPU throttle level. A request is either engaged or not engaged; there is no partial state.

On every clock edge the arbiter looks at the engaged requests whose priority is valid and picks the one with the highest priority. It then registers that request's CPU percentage and GPU level, raises a throttling flag, and reports the index of the winning request. If no request is eligible, all outputs fall back to zero throttling. A clock pulse skipper downstream consumes these outputs.

Top module: `thr_arb`

## Requirements
- R1: Request bit 0 is the mild thermal event and bit 1 is the severe thermal event. Bits 2 to 6 are overcurrent alarms 1 to 5. A bit at 1 means its event is engaged, and `win_idx_o` reports the winner by this bit number.
- R2: Among the engaged events with a valid priority, the event with the numerically largest priority wins.
- R3: When two or more eligible engaged events have the same priority, the event with the lowest bit number wins.
- R4: A priority of 1 to 100 is valid. An event whose priority is 0 or greater than 100 never wins, even while it is engaged.
- R5: While an event wins, `cpu_pct_o` equals that event's CPU skip percentage and `gpu_lvl_o` equals its GPU level. The GPU level codes are 0 = none (0%), 1 = low (50%), 2 = medium (75%), 3 = high (85%).
- R6: When no event is eligible, `cpu_pct_o` is 0, `gpu_lvl_o` is 0 (none), `throttle_o` is low and `win_idx_o` is 0.
- R7: The outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R8: An active-low reset asynchronously clears all outputs to the idle values of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 7 | Engaged flag per event |
| prio_i | input | 49 | Per-event priority, 7 bits each, event k at bits [7k+6:7k] |
| cpu_pct_i | input | 49 | Per-event CPU skip percentage, 7 bits each |
| gpu_lvl_i | input | 14 | Per-event GPU level code, 2 bits each |
| cpu_pct_o | output | 7 | Selected CPU skip percentage |
| gpu_lvl_o | output | 2 | Selected GPU level code |
| throttle_o | output | 1 | High while some event wins |
| win_idx_o | output | 3 | Bit number of the winning event |

## Verification
The assertions assume that the configuration buses stay constant from one edge to the next, or at least that they are read only as sampled at each edge. They also assume that the CPU percentages are used as given, without any range limit. The bench changes configuration and requests only at falling edges, so every value a property compares against is a clean sample from the edge before. Priorities in the stimulus include the boundary values 0, 1, 100 and 101, which exercise the eligibility rule directly.

// File: rtl/thr_arb.sv
module thr_arb #(
  parameter int NUM_EV   = 7,
  parameter int PRIO_W   = 7,
  parameter int PCT_W    = 7,
  parameter int LVL_W    = 2,
  parameter int PRIO_MAX = 100,
  localparam int IDX_W   = $clog2(NUM_EV)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EV-1:0]        req_i,
  input  logic [NUM_EV*PRIO_W-1:0] prio_i,
  input  logic [NUM_EV*PCT_W-1:0]  cpu_pct_i,
  input  logic [NUM_EV*LVL_W-1:0]  gpu_lvl_i,
  output logic [PCT_W-1:0]         cpu_pct_o,
  output logic [LVL_W-1:0]         gpu_lvl_o,
  output logic                     throttle_o,
  output logic [IDX_W-1:0]         win_idx_o
);

  localparam logic [PRIO_W-1:0] PMAX = PRIO_W'(PRIO_MAX);

  logic [NUM_EV-1:0] elig;
  logic              hit;
  logic [IDX_W-1:0]  best;
  logic [PRIO_W-1:0] best_p;

  for (genvar k = 0; k < NUM_EV; k++) begin : g_elig
    wire [PRIO_W-1:0] p = prio_i[k*PRIO_W +: PRIO_W];
    assign elig[k] = req_i[k] && (p != '0) && (p <= PMAX);
  end

  always_comb begin
    hit    = 1'b0;
    best   = '0;
    best_p = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (elig[i] && (!hit || prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
        hit    = 1'b1;
        best   = IDX_W'(i);
        best_p = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_pct_o  <= '0;
      gpu_lvl_o  <= '0;
      throttle_o <= 1'b0;
      win_idx_o  <= '0;
    end else begin
      throttle_o <= hit;
      win_idx_o  <= best;
      cpu_pct_o  <= hit ? cpu_pct_i[best*PCT_W +: PCT_W] : '0;
      gpu_lvl_o  <= hit ? gpu_lvl_i[best*LVL_W +: LVL_W] : '0;
    end
  end

endmodule

// File: rtl/thr_arb_chk.sv
module thr_arb_chk #(
  parameter int NUM_EV   = 7,
  parameter int PRIO_W   = 7,
  parameter int PCT_W    = 7,
  parameter int LVL_W    = 2,
  parameter int PRIO_MAX = 100,
  localparam int IDX_W   = $clog2(NUM_EV)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_EV-1:0]        req_i,
  input logic [NUM_EV*PRIO_W-1:0] prio_i,
  input logic [NUM_EV*PCT_W-1:0]  cpu_pct_i,
  input logic [NUM_EV*LVL_W-1:0]  gpu_lvl_i,
  input logic [PCT_W-1:0]         cpu_pct_o,
  input logic [LVL_W-1:0]         gpu_lvl_o,
  input logic                     throttle_o,
  input logic [IDX_W-1:0]         win_idx_o
);

  logic [NUM_EV-1:0]        req_q;
  logic [NUM_EV*PRIO_W-1:0] prio_q;
  logic [NUM_EV*PCT_W-1:0]  cpu_q;
  logic [NUM_EV*LVL_W-1:0]  gpu_q;
  logic                     seen;

  always_ff @(posedge clk) begin
    req_q  <= req_i;
    prio_q <= prio_i;
    cpu_q  <= cpu_pct_i;
    gpu_q  <= gpu_lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  logic [PRIO_W-1:0] wp;
  logic              any_ok, beaten, tie_lower;

  always_comb begin
    wp        = prio_q[win_idx_o*PRIO_W +: PRIO_W];
    any_ok    = 1'b0;
    beaten    = 1'b0;
    tie_lower = 1'b0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (req_q[i] && int'(prio_q[i*PRIO_W +: PRIO_W]) >= 1 &&
          int'(prio_q[i*PRIO_W +: PRIO_W]) <= PRIO_MAX) begin
        any_ok = 1'b1;
        if (prio_q[i*PRIO_W +: PRIO_W] > wp) beaten = 1'b1;
        if (prio_q[i*PRIO_W +: PRIO_W] == wp && i < int'(win_idx_o)) tie_lower = 1'b1;
      end
    end
  end

  p_win_engaged_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seen && throttle_o |-> req_q[win_idx_o]);
  p_win_highest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen && throttle_o |-> !beaten);
  p_tie_low_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen && throttle_o |-> !tie_lower);
  p_prio_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen && throttle_o |-> (int'(wp) >= 1 && int'(wp) <= PRIO_MAX));
  p_settings_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen && throttle_o |-> (cpu_pct_o == cpu_q[win_idx_o*PCT_W +: PCT_W] &&
                            gpu_lvl_o == gpu_q[win_idx_o*LVL_W +: LVL_W]));
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !throttle_o |-> (cpu_pct_o == '0 && gpu_lvl_o == '0 && win_idx_o == '0));
  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> throttle_o == any_ok);
  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n && $past(!rst_n) |-> (!throttle_o && cpu_pct_o == '0 && gpu_lvl_o == '0));

endmodule

bind thr_arb thr_arb_chk #(
  .NUM_EV(NUM_EV), .PRIO_W(PRIO_W), .PCT_W(PCT_W), .LVL_W(LVL_W), .PRIO_MAX(PRIO_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_i),
  .cpu_pct_i(cpu_pct_i), .gpu_lvl_i(gpu_lvl_i), .cpu_pct_o(cpu_pct_o),
  .gpu_lvl_o(gpu_lvl_o), .throttle_o(throttle_o), .win_idx_o(win_idx_o)
);

// File: tb/thr_arb_tb.sv
module thr_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  req;
  logic [6:0]  prio [NV];
  logic [6:0]  cpu  [NV];
  logic [1:0]  gpu  [NV];
  logic [48:0] prio_bus, cpu_bus;
  logic [13:0] gpu_bus;
  logic [6:0]  cpu_pct_o;
  logic [1:0]  gpu_lvl_o;
  logic        throttle_o;
  logic [2:0]  win_idx_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < NV; k++) begin
      prio_bus[k*7 +: 7] = prio[k];
      cpu_bus[k*7 +: 7]  = cpu[k];
      gpu_bus[k*2 +: 2]  = gpu[k];
    end
  end

  thr_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio_bus),
    .cpu_pct_i(cpu_bus), .gpu_lvl_i(gpu_bus), .cpu_pct_o(cpu_pct_o),
    .gpu_lvl_o(gpu_lvl_o), .throttle_o(throttle_o), .win_idx_o(win_idx_o)
  );

  // {req[6:0], cpu[6:0], gpu[1:0], throttle, win[2:0]}
  localparam int NVEC = 10;
  localparam logic [19:0] VEC [NVEC] = '{
    {7'b0000000, 7'd0,  2'd0, 1'b0, 3'd0},
    {7'b0000001, 7'd50, 2'd1, 1'b1, 3'd0},
    {7'b0000011, 7'd85, 2'd3, 1'b1, 3'd1},
    {7'b0000100, 7'd20, 2'd0, 1'b1, 3'd2},
    {7'b0011000, 7'd40, 2'd2, 1'b1, 3'd3},
    {7'b1000001, 7'd70, 2'd2, 1'b1, 3'd6},
    {7'b0100100, 7'd20, 2'd0, 1'b1, 3'd2},
    {7'b1111111, 7'd85, 2'd3, 1'b1, 3'd1},
    {7'b1111101, 7'd70, 2'd2, 1'b1, 3'd6},
    {7'b0110000, 7'd45, 2'd1, 1'b1, 3'd4}
  };

  task automatic check(input string tag, input logic [6:0] ec, input logic [1:0] eg,
                       input logic et, input logic [2:0] ew);
    n_chk++;
    if (cpu_pct_o !== ec || gpu_lvl_o !== eg || throttle_o !== et || win_idx_o !== ew) begin
      n_bad++;
      $display("FAIL %s: got cpu=%0d gpu=%0d thr=%0b win=%0d, want cpu=%0d gpu=%0d thr=%0b win=%0d",
               tag, cpu_pct_o, gpu_lvl_o, throttle_o, win_idx_o, ec, eg, et, ew);
    end
  endtask

  task automatic step(input logic [6:0] r);
    @(negedge clk);
    req = r;
    @(posedge clk);
    #1;
  endtask

  task automatic base_cfg();
    prio = '{80, 100, 30, 60, 60, 10, 90};
    cpu  = '{50, 85, 20, 40, 45, 5, 70};
    gpu  = '{2'd1, 2'd3, 2'd0, 2'd2, 2'd1, 2'd1, 2'd2};
  endtask

  initial begin
    rst_n = 1'b0;
    req   = '1;
    base_cfg();
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset with requests engaged", 7'd0, 2'd0, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][19:13]);
      check($sformatf("R1/R2/R3/R5/R6 vector %0d", v),
            VEC[v][12:6], VEC[v][5:4], VEC[v][3], VEC[v][2:0]);
    end

    // R7: output holds until the next edge
    step(7'b0000000);
    @(negedge clk);
    req = 7'b0000001;
    #1;
    check("R7 before edge", 7'd0, 2'd0, 1'b0, 3'd0);
    @(posedge clk);
    #1;
    check("R7 after edge", 7'd50, 2'd1, 1'b1, 3'd0);

    // R4: priority 0 disables
    @(negedge clk);
    prio[0] = 7'd0;
    step(7'b0000001);
    check("R4 priority 0", 7'd0, 2'd0, 1'b0, 3'd0);

    // R4: priority 101 disables, lower valid event wins
    @(negedge clk);
    prio[1] = 7'd101;
    step(7'b0100010);
    check("R4 priority 101", 7'd5, 2'd1, 1'b1, 3'd5);

    // R4: priority 1 is valid
    @(negedge clk);
    prio[2] = 7'd1;
    step(7'b0000100);
    check("R4 priority 1", 7'd20, 2'd0, 1'b1, 3'd2);

    // R2: priority 100 beats 99
    @(negedge clk);
    base_cfg();
    prio[6] = 7'd99;
    step(7'b1000010);
    check("R2 100 over 99", 7'd85, 2'd3, 1'b1, 3'd1);

    // R3: full tie, lowest index wins
    @(negedge clk);
    for (int k = 0; k < NV; k++) prio[k] = 7'd42;
    step(7'b1110100);
    check("R3 all tied", 7'd20, 2'd0, 1'b1, 3'd2);

    // R8: asynchronous reset mid-cycle
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check("R8 async clear", 7'd0, 2'd0, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule